// File: doc/BRIEF.md
# GPIO Pin Function Register File

This block is the register core of a general-purpose I/O controller for up to 64 pins. By default it has 54 pins, split into two 32-bit banks. A 32-bit register bus has a byte address, a write strobe, write data and a combinational read-data return. Through it, software gives each pin a 3-bit function code, raises or lowers pin outputs, and reads the synchronised level of every pin.

Each function-select word holds the 3-bit fields of ten pins. The block exports every pin's code so that pad logic outside the block can route alternate functions. It also drives a per-pin output enable, which is high only while the pin is coded as a plain output.

Output values never need a read-modify-write. Separate write-one-to-set and write-one-to-clear words change only the bits written as 1. Pin levels pass through a two-flop synchroniser before they can be read.

Top module: `pinfn_regfile`

## Requirements
- R1: While reset is asserted, and until the first write after reset, every function field reads 000, and `pin_out`, `pin_oe` and `pin_fn` are all zero.
- R2: Function-select word k (byte address 4*k, k = 0..5) holds pin n = 10*k + j in bits [3*j+2 : 3*j]. A write to that word updates those fields one cycle later on `pin_fn` and in read-back.
- R3: The function codes are 000 input, 001 output, 100/101/110/111 alternates 0 to 3, 011 alternate 4 and 010 alternate 5. `pin_oe[n]` is 1 exactly when pin n holds code 001.
- R4: Writing byte address 0x1C (bank 0) or 0x20 (bank 1) sets the output latch of pin 32*b + i for every data bit i that is 1. Data bits that are 0 leave their latches unchanged.
- R5: Writing byte address 0x28 (bank 0) or 0x2C (bank 1) clears the output latch of pin 32*b + i for every data bit i that is 1. Data bits that are 0 leave their latches unchanged.
- R6: Byte addresses 0x34 and 0x38 return the levels of banks 0 and 1, with pin n at bit n mod 32. A change on `pin_in` appears in a read sampled after the second rising edge, and not after only the first.
- R7: Fields and bits that belong to pin indices at or above the pin count ignore writes and read as 0. This covers bits 31:30 of every function word, pins 54 to 59 of word 5, and bits 31:22 of the bank-1 level word.
- R8: The set and clear words read as 0. Unmapped addresses ignore writes and read 0. This includes byte address 0x18 and every address whose two low bits are not 00.
- R9: The output latch does not depend on the function code. Changing a pin's function leaves its latch value unchanged, and `pin_out` always shows the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_in | input | 54 | Pin levels from the pads, asynchronous |
| pin_out | output | 54 | Output latch value per pin |
| pin_oe | output | 54 | Output enable per pin |
| pin_fn | output | 162 | Function code per pin, pin n at bits [3n+2:3n] |

## Verification
A corrupted function field shows at once on `pin_fn` and `pin_oe`, and on the next read of its select word. The bench therefore compares both the ports and the read-back after each write.

A wrong output latch shows on `pin_out` one cycle after the offending set or clear write. The bench checks that bits written as 1 changed and that bits written as 0 did not.

Synchroniser faults show as a level read that is one edge early or late. The bench samples the level register at both the first and the second cycle after a pin change.

// File: rtl/pinfn_pkg.sv
package pinfn_pkg;

   localparam int unsigned FN_W = 3;

   typedef enum logic [FN_W-1:0] {
      FN_IN   = 3'b000,
      FN_OUT  = 3'b001,
      FN_ALT5 = 3'b010,
      FN_ALT4 = 3'b011,
      FN_ALT0 = 3'b100,
      FN_ALT1 = 3'b101,
      FN_ALT2 = 3'b110,
      FN_ALT3 = 3'b111
   } pin_fn_e;

   // byte offsets of the register groups; banked groups step by one word
   localparam int unsigned OFS_SEL = 'h00;
   localparam int unsigned OFS_SET = 'h1C;
   localparam int unsigned OFS_CLR = 'h28;
   localparam int unsigned OFS_LEV = 'h34;

endpackage

// File: rtl/pinfn_sync.sv
module pinfn_sync #(
   parameter int unsigned WIDTH  = 54,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pinfn_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= din;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pinfn_sel_regs.sv
module pinfn_sel_regs import pinfn_pkg::*; #(
   parameter int unsigned NUM_PINS = 54,
   parameter int unsigned PER_REG  = 10,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 6,
   localparam int unsigned NUM_REG = (NUM_PINS + PER_REG - 1) / PER_REG,
   localparam int unsigned SLOTS   = NUM_REG * PER_REG
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_REG-1:0]       sel_wr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [DATA_W-1:0]        rd_word,
   output logic [FN_W*NUM_PINS-1:0] fn_flat
);

   localparam int unsigned FLD_BITS = PER_REG * FN_W;

   if (FLD_BITS > DATA_W) begin : g_bad_pack
      $error("pinfn_sel_regs: fields do not fit a data word");
   end

   logic [FN_W*SLOTS-1:0] fld_pad;
   logic [DATA_W-1:0]     words [NUM_REG];

   // one field per slot; slots past the pin count are tied off
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < NUM_PINS) begin : g_live
         localparam int unsigned REG = i / PER_REG;
         localparam int unsigned LSB = (i % PER_REG) * FN_W;
         logic [FN_W-1:0] fld_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           fld_q <= FN_IN;
            else if (sel_wr[REG]) fld_q <= wr_data[LSB +: FN_W];
         end
         assign fld_pad[i*FN_W +: FN_W] = fld_q;
      end else begin : g_tie
         assign fld_pad[i*FN_W +: FN_W] = '0;
      end
   end

   for (genvar r = 0; r < NUM_REG; r++) begin : g_word
      assign words[r] = DATA_W'(fld_pad[r*FLD_BITS +: FLD_BITS]);
   end

   always_comb begin
      rd_word = '0;
      for (int r = 0; r < NUM_REG; r++) begin
         if (rd_idx == IDX_W'(r)) rd_word = words[r];
      end
   end

   assign fn_flat = fld_pad[FN_W*NUM_PINS-1:0];

   logic unused_hi;
   if (FLD_BITS < DATA_W) begin : g_spare
      assign unused_hi = ^wr_data[DATA_W-1:FLD_BITS];
   end else begin : g_nospare
      assign unused_hi = 1'b0;
   end

endmodule

// File: rtl/pinfn_out_latch.sv
module pinfn_out_latch #(
   parameter int unsigned NUM_PINS  = 54,
   parameter int unsigned DATA_W    = 32,
   localparam int unsigned NUM_BANK = (NUM_PINS + DATA_W - 1) / DATA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_BANK-1:0] set_wr,
   input  logic [NUM_BANK-1:0] clr_wr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [NUM_PINS-1:0] out_q
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int unsigned BANK = p / DATA_W;
      localparam int unsigned BIT  = p % DATA_W;
      logic hit_set, hit_clr;
      assign hit_set = set_wr[BANK] & wr_data[BIT];
      assign hit_clr = clr_wr[BANK] & wr_data[BIT];
      // clear takes priority should both strobes ever meet
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       out_q[p] <= 1'b0;
         else if (hit_clr) out_q[p] <= 1'b0;
         else if (hit_set) out_q[p] <= 1'b1;
      end
   end

endmodule

// File: rtl/pinfn_regfile.sv
module pinfn_regfile import pinfn_pkg::*; #(
   parameter int unsigned NUM_PINS    = 54,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned PINS_PER_SEL = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [DATA_W-1:0]        rd_data,
   input  logic [NUM_PINS-1:0]      pin_in,
   output logic [NUM_PINS-1:0]      pin_out,
   output logic [NUM_PINS-1:0]      pin_oe,
   output logic [FN_W*NUM_PINS-1:0] pin_fn
);

   localparam int unsigned NUM_SEL  = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL;
   localparam int unsigned NUM_BANK = (NUM_PINS + DATA_W - 1) / DATA_W;
   localparam int unsigned IDX_W    = ADDR_W - 2;
   localparam int unsigned SEL_IDX  = OFS_SEL / 4;
   localparam int unsigned SET_IDX  = OFS_SET / 4;
   localparam int unsigned CLR_IDX  = OFS_CLR / 4;
   localparam int unsigned LEV_IDX  = OFS_LEV / 4;

   if (DATA_W != 32) begin : g_bad_width
      $error("pinfn_regfile: DATA_W must be 32");
   end
   if (NUM_BANK != 2) begin : g_bad_pins
      $error("pinfn_regfile: NUM_PINS must lie in 33..64");
   end
   if (SEL_IDX + NUM_SEL > SET_IDX) begin : g_bad_sel
      $error("pinfn_regfile: select words overlap the set words");
   end
   if ((LEV_IDX + NUM_BANK) > (1 << IDX_W)) begin : g_bad_addr
      $error("pinfn_regfile: ADDR_W too narrow for the map");
   end

   logic [IDX_W-1:0]           word_idx;
   logic                       aligned;
   logic [NUM_SEL-1:0]         sel_wr;
   logic [NUM_BANK-1:0]        set_wr, clr_wr;
   logic [DATA_W-1:0]          sel_word;
   logic [NUM_PINS-1:0]        lev_q;
   logic [NUM_BANK*DATA_W-1:0] lev_pad;

   assign word_idx = addr[ADDR_W-1:2];
   assign aligned  = (addr[1:0] == 2'b00);

   for (genvar r = 0; r < NUM_SEL; r++) begin : g_selwr
      assign sel_wr[r] = wr_en & aligned & (word_idx == IDX_W'(SEL_IDX + r));
   end

   for (genvar b = 0; b < NUM_BANK; b++) begin : g_bankwr
      assign set_wr[b] = wr_en & aligned & (word_idx == IDX_W'(SET_IDX + b));
      assign clr_wr[b] = wr_en & aligned & (word_idx == IDX_W'(CLR_IDX + b));
   end

   pinfn_sel_regs #(
      .NUM_PINS (NUM_PINS),
      .PER_REG  (PINS_PER_SEL),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W)
   ) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_wr  (sel_wr),
      .wr_data (wr_data),
      .rd_idx  (word_idx - IDX_W'(SEL_IDX)),
      .rd_word (sel_word),
      .fn_flat (pin_fn)
   );

   pinfn_out_latch #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_wr  (set_wr),
      .clr_wr  (clr_wr),
      .wr_data (wr_data),
      .out_q   (pin_out)
   );

   pinfn_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_in),
      .dout  (lev_q)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
      assign pin_oe[p] = (pin_fn[p*FN_W +: FN_W] == FN_OUT);
   end

   always_comb begin
      lev_pad = '0;
      lev_pad[NUM_PINS-1:0] = lev_q;
   end

   always_comb begin
      rd_data = '0;
      if (aligned) begin
         if ((int'(word_idx) >= SEL_IDX) && (int'(word_idx) < SEL_IDX + NUM_SEL))
            rd_data = sel_word;
         for (int b = 0; b < NUM_BANK; b++) begin
            if (int'(word_idx) == LEV_IDX + b) rd_data = lev_pad[b*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/pinfn_regfile_chk.sv
module pinfn_regfile_chk import pinfn_pkg::*; #(
   parameter int unsigned NUM_PINS     = 54,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned PINS_PER_SEL = 10
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        addr,
   input logic                     wr_en,
   input logic [DATA_W-1:0]        wr_data,
   input logic [DATA_W-1:0]        rd_data,
   input logic [NUM_PINS-1:0]      pin_out,
   input logic [NUM_PINS-1:0]      pin_oe,
   input logic [FN_W*NUM_PINS-1:0] pin_fn
);

   localparam int unsigned HI_W  = NUM_PINS - DATA_W;
   localparam int unsigned FLD_B = PINS_PER_SEL * FN_W;
   localparam logic [ADDR_W-1:0] A_SEL0 = ADDR_W'(OFS_SEL);
   localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(OFS_SET);
   localparam logic [ADDR_W-1:0] A_SET1 = ADDR_W'(OFS_SET + 4);
   localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_CLR1 = ADDR_W'(OFS_CLR + 4);

   // R1: one cycle into reset everything is back to idle
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (pin_out == '0 && pin_oe == '0 && pin_fn == '0));

   // R2: a write to word 0 lands on the exported fields of pins 0..9
   a_r2_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SEL0) |=> (pin_fn[FLD_B-1:0] == $past(wr_data[FLD_B-1:0])));

   // R3: output enable follows code 001 on every pin
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_r3
      a_r3_oe_code: assert property (@(posedge clk) disable iff (!rst_n)
         pin_oe[p] == (pin_fn[p*FN_W +: FN_W] == FN_OUT));
   end

   // R4: ones raise the latch, zeros keep it
   a_r4_set_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SET0) |=>
      ((pin_out[DATA_W-1:0] & $past(wr_data)) == $past(wr_data)));
   a_r4_keep_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SET0) |=>
      ((pin_out[DATA_W-1:0] & ~$past(wr_data)) == ($past(pin_out[DATA_W-1:0]) & ~$past(wr_data))));
   a_r4_set_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SET1) |=>
      ((pin_out[NUM_PINS-1:DATA_W] & $past(wr_data[HI_W-1:0])) == $past(wr_data[HI_W-1:0])));

   // R5: ones lower the latch
   a_r5_clr_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CLR0) |=> ((pin_out[DATA_W-1:0] & $past(wr_data)) == '0));
   a_r5_clr_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CLR1) |=>
      ((pin_out[NUM_PINS-1:DATA_W] & $past(wr_data[HI_W-1:0])) == '0));

   // R7: bits above the packed fields of a select word read 0
   a_r7_sel_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr < A_SET0) |-> (rd_data[DATA_W-1:FLD_B] == '0));

   // R8: set and clear words read 0
   a_r8_setclr_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_SET0 || addr == A_SET1 || addr == A_CLR0 || addr == A_CLR1) |-> (rd_data == '0));

endmodule

bind pinfn_regfile pinfn_regfile_chk #(
   .NUM_PINS     (NUM_PINS),
   .DATA_W       (DATA_W),
   .ADDR_W       (ADDR_W),
   .PINS_PER_SEL (PINS_PER_SEL)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .pin_out (pin_out),
   .pin_oe  (pin_oe),
   .pin_fn  (pin_fn)
);

// File: tb/pinfn_regfile_tb.sv
module pinfn_regfile_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 54;
   localparam int WATCHDOG   = 20000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [7:0]      addr = '0;
   logic            wr_en = 1'b0;
   logic [31:0]     wr_data = '0;
   logic [31:0]     rd_data;
   logic [NP-1:0]   pin_in = '0;
   logic [NP-1:0]   pin_out;
   logic [NP-1:0]   pin_oe;
   logic [3*NP-1:0] pin_fn;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pinfn_regfile u_dut (
      .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en),
      .wr_data (wr_data), .rd_data (rd_data), .pin_in (pin_in),
      .pin_out (pin_out), .pin_oe (pin_oe), .pin_fn (pin_fn)
   );

   // {req, write, address, data, expected read}
   localparam int NV = 16;
   localparam logic [76:0] VEC [NV] = '{
      {4'd1, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000},
      {4'd1, 1'b0, 8'h34, 32'h0000_0000, 32'h0000_0000},
      {4'd2, 1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0000_0000},
      {4'd7, 1'b0, 8'h00, 32'h0000_0000, 32'h3FFF_FFFF},
      {4'd7, 1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0000_0000},
      {4'd7, 1'b0, 8'h14, 32'h0000_0000, 32'h0000_0FFF},
      {4'd2, 1'b1, 8'h04, 32'h0000_0008, 32'h0000_0000},
      {4'd2, 1'b0, 8'h04, 32'h0000_0000, 32'h0000_0008},
      {4'd8, 1'b1, 8'h1C, 32'hA5A5_A5A5, 32'h0000_0000},
      {4'd8, 1'b0, 8'h1C, 32'h0000_0000, 32'h0000_0000},
      {4'd8, 1'b0, 8'h2C, 32'h0000_0000, 32'h0000_0000},
      {4'd8, 1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0000_0000},
      {4'd8, 1'b0, 8'h18, 32'h0000_0000, 32'h0000_0000},
      {4'd8, 1'b0, 8'h01, 32'h0000_0000, 32'h0000_0000},
      {4'd2, 1'b1, 8'h00, 32'h0000_0000, 32'h0000_0000},
      {4'd2, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      check("R1 pin_out in reset", 64'(pin_out), 64'h0);
      check("R1 pin_oe in reset", 64'(pin_oe), 64'h0);
      check("R1 pin_fn in reset", 64'(pin_fn[63:0]), 64'h0);
      rst_n = 1'b1;

      // table walk (tags R1 R2 R7 R8 held in the req field)
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][72]) begin
            bus_wr(VEC[i][71:64], VEC[i][63:32]);
         end else begin
            bus_rd(VEC[i][71:64], rd);
            n_chk++;
            if (rd !== VEC[i][31:0]) begin
               n_bad++;
               $display("FAIL R%0d table step %0d actual=%h expected=%h",
                        VEC[i][76:73], i, rd, VEC[i][31:0]);
            end
         end
      end

      #1;
      // R2/R3: pin 11 holds 001, pins 50..53 hold 111
      check("R2 pin 11 field", 64'(pin_fn[35:33]), 64'h1);
      check("R2 pin 53 field", 64'(pin_fn[161:159]), 64'h7);
      check("R3 oe only on pin 11", 64'(pin_oe), 64'h800);
      check("R4 set bank 0", 64'(pin_out), 64'hA5A5_A5A5);

      bus_wr(8'h1C, 32'h0000_0002);
      check("R4 zero bits keep", 64'(pin_out), 64'hA5A5_A5A7);
      bus_wr(8'h28, 32'h0000_00FF);
      check("R5 clear bank 0", 64'(pin_out), 64'hA5A5_A500);
      bus_wr(8'h20, 32'hFFFF_FFFF);
      check("R4 R7 set bank 1", 64'(pin_out), 64'h003F_FFFF_A5A5_A500);
      bus_wr(8'h2C, 32'h0000_0001);
      check("R5 clear bank 1", 64'(pin_out), 64'h003F_FFFE_A5A5_A500);

      // R8: unmapped and misaligned writes leave state alone
      bus_wr(8'h30, 32'hFFFF_FFFF);
      bus_wr(8'h1D, 32'hFFFF_FFFF);
      bus_wr(8'h05, 32'hFFFF_FFFF);
      check("R8 unmapped write pin_out", 64'(pin_out), 64'h003F_FFFE_A5A5_A500);
      check("R8 unmapped write pin_fn", 64'(pin_fn[35:0]), 64'h2_0000_0000);

      // R9: function change does not touch the latch
      bus_wr(8'h04, 32'h0000_0000);
      check("R9 latch kept after fn change", 64'(pin_out), 64'h003F_FFFE_A5A5_A500);
      check("R3 oe drops with input code", 64'(pin_oe), 64'h0);

      // R3: code sweep on pin 0
      for (int c = 0; c < 8; c++) begin
         bus_wr(8'h00, 32'(c));
         check("R3 pin 0 code", 64'(pin_fn[2:0]), 64'(c));
         check("R3 pin 0 oe", 64'(pin_oe[0]), 64'(c == 1));
      end
      bus_wr(8'h00, 32'h0);

      // R6: two-edge latency of the level path
      @(negedge clk);
      pin_in = '0;
      pin_in[0] = 1'b1; pin_in[32] = 1'b1; pin_in[53] = 1'b1;
      addr = 8'h34;
      @(negedge clk);
      #1 check("R6 not visible after one edge", 64'(rd_data), 64'h0);
      @(negedge clk);
      #1 check("R6 bank 0 level", 64'(rd_data), 64'h1);
      bus_rd(8'h38, rd);
      check("R6 R7 bank 1 level", 64'(rd), 64'h0020_0001);

      // R1: reset again clears everything
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 pin_out after reset", 64'(pin_out), 64'h0);
      check("R1 pin_fn after reset", 64'(pin_fn[63:0]), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule